// File: doc/BRIEF.md
# Triplicated Iterative Fixed-Width Multiplier

This block multiplies two unsigned N-bit operands and returns the high N bits of their 2N-bit product. It does not build a full partial-product array. Instead it steps one small compression element across the multiplier bits. In each step the element folds ROWS shifted partial-product rows into a carry-save accumulator, so one product needs N/ROWS steps followed by one final carry-propagate add. The compression element is built three times. All three copies see the same inputs, and a bitwise majority vote picks both the sum and the carry before they are written back into the one shared accumulator. A fault in one copy is therefore masked within the same step and never reaches the next step.

Operands enter through a valid/ready handshake. `in_ready` is high only while the block is idle. Back-pressure is simply `in_ready` going low for the whole computation. An offer made while `in_ready` is low is not taken, and the sender must keep `in_valid` up until it sees `in_ready`. The result side has no back-pressure: `out_valid` is a one-cycle pulse, and `out_res` holds its value until the next result replaces it. A combinational disagreement flag and a sticky flag report whether the copies differed. A test-only fault port can force one bit of one copy's sum output to a fixed value.

Top module: `tmr_mult`

## Requirements
- R1: For operands accepted on a rising edge where `in_valid` and `in_ready` are both high, `out_res` equals floor(in_a × in_b / 2^N), with no rounding.
- R2: `out_valid` is high for exactly one cycle. It rises on the (N/ROWS+1)-th rising edge after the accepting edge, which is edge 17 for the default N=64, ROWS=4.
- R3: `in_ready` is low from the accepting edge until `out_valid` rises. An `in_valid` offered while `in_ready` is low is ignored: it produces no extra result and does not change the pending result.
- R4: `out_res` changes only on the edge that raises `out_valid`.
- R5: When `flt_sel` is 0, 1 or 2, bit `flt_bit` of that copy's sum output is forced to `flt_val`, and the result still satisfies R1. When `flt_sel` is 3, no fault is injected.
- R6: `mis_now` is high in a computation cycle where the three copies do not all agree. It is never high while `flt_sel` is 3.
- R7: `mis_sticky` is set by any cycle with `mis_now` high and cleared on the next accepting edge. It is read in the cycle `out_valid` is high, and it then covers only that operation.
- R8: After reset, `in_ready`=1, `out_valid`=0, `out_res`=0, `mis_now`=0 and `mis_sticky`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand offer |
| in_ready | output | 1 | High when idle and able to accept operands |
| in_a | input | N | Multiplicand |
| in_b | input | N | Multiplier |
| out_valid | output | 1 | One-cycle result strobe |
| out_res | output | N | High half of the product, held between results |
| mis_now | output | 1 | Copies disagree in this computation cycle |
| mis_sticky | output | 1 | Some disagreement occurred in the current or last operation |
| flt_sel | input | 2 | Copy selected for fault injection; 3 means none |
| flt_bit | input | log2(2N) | Sum bit index that is forced |
| flt_val | input | 1 | Value the forced bit takes |

## Verification
Two events can fall on the same edge: the result strobe of one operation and the acceptance of the next. The same edge that raises `out_valid` leaves `in_ready` high, so a new offer is taken at once.

The bench provokes this by offering the next operands in the cycle the result appears. It runs an operation with a guaranteed disagreement (a zero multiplicand with a stuck-at-one sum bit) directly followed by a fault-free one. A scoreboard then checks that each result, and the sticky flag read with it, belongs to its own operation. An ignored offer during a busy period is judged the same way, by the absence of any unexpected result.

// File: rtl/tmr_mult_pkg.sv
package tmr_mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ADD  = 2'd2
  } tmr_state_e;

  localparam logic [1:0] FAULT_NONE = 2'd3;
endpackage

// File: rtl/tmr_mult_pe.sv
// One compression element: folds ROWS partial-product rows into the
// carry-save accumulator through a cascade of 4-2 compressors.
module tmr_mult_pe #(
  parameter int N    = 64,
  parameter int ROWS = 4,
  parameter int SW   = 4
) (
  input  logic [N-1:0]   mcand,
  input  logic [ROWS-1:0] mbits,
  input  logic [SW-1:0]  stage,
  input  logic [2*N-1:0] acc_s,
  input  logic [2*N-1:0] acc_c,
  output logic [2*N-1:0] nxt_s,
  output logic [2*N-1:0] nxt_c
);
  localparam int PW   = 2 * N;
  localparam int NCMP = ROWS / 2;

  logic [PW-1:0] row [ROWS];
  logic [PW-1:0] ch_s [NCMP+1];
  logic [PW-1:0] ch_c [NCMP+1];

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    logic [PW-1:0] base;
    assign base   = {{N{1'b0}}, mcand & {N{mbits[j]}}};
    assign row[j] = base << (PW'(stage) * PW'(ROWS) + PW'(j));
  end

  assign ch_s[0] = acc_s;
  assign ch_c[0] = acc_c;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    logic [PW-1:0] s1, c1;
    // first 3:2 stage of the 4-2 compressor
    assign s1 = ch_s[k] ^ ch_c[k] ^ row[2*k];
    assign c1 = ((ch_s[k] & ch_c[k]) | (ch_s[k] & row[2*k]) |
                 (ch_c[k] & row[2*k])) << 1;
    // second 3:2 stage
    assign ch_s[k+1] = s1 ^ c1 ^ row[2*k+1];
    assign ch_c[k+1] = ((s1 & c1) | (s1 & row[2*k+1]) |
                        (c1 & row[2*k+1])) << 1;
  end

  assign nxt_s = ch_s[NCMP];
  assign nxt_c = ch_c[NCMP];
endmodule

// File: rtl/tmr_mult_vote.sv
module tmr_mult_vote #(
  parameter int W = 128
) (
  input  logic [W-1:0] v0,
  input  logic [W-1:0] v1,
  input  logic [W-1:0] v2,
  output logic [W-1:0] maj,
  output logic         diff
);
  assign maj  = (v0 & v1) | (v0 & v2) | (v1 & v2);
  assign diff = (v0 != v1) || (v0 != v2);
endmodule

// File: rtl/tmr_mult.sv
module tmr_mult
  import tmr_mult_pkg::*;
#(
  parameter int N    = 64,
  parameter int ROWS = 4,
  localparam int PW     = 2 * N,
  localparam int BW     = $clog2(PW),
  localparam int STAGES = N / ROWS,
  localparam int SW     = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_a,
  input  logic [N-1:0]  in_b,
  output logic          out_valid,
  output logic [N-1:0]  out_res,
  output logic          mis_now,
  output logic          mis_sticky,
  input  logic [1:0]    flt_sel,
  input  logic [BW-1:0] flt_bit,
  input  logic          flt_val
);
  tmr_state_e    state;
  logic [N-1:0]  a_q, b_q;
  logic [SW-1:0] stage;
  logic [PW-1:0] acc_s, acc_c;
  logic [N-1:0]  res_q;
  logic          vld_q, sticky_q;

  logic [ROWS-1:0] mbits;
  logic [PW-1:0]   pe_s [3];
  logic [PW-1:0]   pe_c [3];
  logic [PW-1:0]   pe_sf [3];
  logic [PW-1:0]   v_s, v_c;
  logic            d_s, d_c;
  logic [PW-1:0]   fmask;
  logic [PW-1:0]   merged;

  assign mbits = b_q[stage*ROWS +: ROWS];
  assign fmask = PW'(1) << flt_bit;

  for (genvar i = 0; i < 3; i++) begin : g_copy
    tmr_mult_pe #(.N(N), .ROWS(ROWS), .SW(SW)) u_pe (
      .mcand (a_q),
      .mbits (mbits),
      .stage (stage),
      .acc_s (acc_s),
      .acc_c (acc_c),
      .nxt_s (pe_s[i]),
      .nxt_c (pe_c[i])
    );
    always_comb begin
      pe_sf[i] = pe_s[i];
      if (flt_sel == 2'(i))
        pe_sf[i] = flt_val ? (pe_s[i] | fmask) : (pe_s[i] & ~fmask);
    end
  end

  tmr_mult_vote #(.W(PW)) u_vote_s (
    .v0(pe_sf[0]), .v1(pe_sf[1]), .v2(pe_sf[2]), .maj(v_s), .diff(d_s)
  );
  tmr_mult_vote #(.W(PW)) u_vote_c (
    .v0(pe_c[0]), .v1(pe_c[1]), .v2(pe_c[2]), .maj(v_c), .diff(d_c)
  );

  assign merged = acc_s + acc_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      stage    <= '0;
      acc_s    <= '0;
      acc_c    <= '0;
      res_q    <= '0;
      vld_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            a_q      <= in_a;
            b_q      <= in_b;
            acc_s    <= '0;
            acc_c    <= '0;
            stage    <= '0;
            sticky_q <= 1'b0;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc_s <= v_s;
          acc_c <= v_c;
          if (d_s || d_c) sticky_q <= 1'b1;
          if (stage == SW'(STAGES - 1)) state <= ST_ADD;
          else stage <= stage + 1'b1;
        end
        ST_ADD: begin
          res_q <= merged[PW-1:N];
          vld_q <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (state == ST_IDLE);
  assign out_valid  = vld_q;
  assign out_res    = res_q;
  assign mis_now    = (state == ST_RUN) && (d_s || d_c);
  assign mis_sticky = sticky_q;
endmodule

// File: rtl/tmr_mult_chk.sv
module tmr_mult_chk #(
  parameter int N    = 64,
  parameter int ROWS = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [N-1:0] out_res,
  input logic         mis_now,
  input logic         mis_sticky,
  input logic [1:0]   flt_sel
);
  localparam int LAT = N / ROWS + 1;
  localparam int CW  = $clog2(LAT + 3) + 1;

  logic [CW-1:0] since;
  logic          accept;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (accept) since <= CW'(1);
    else if (since != '0 && since <= CW'(LAT)) since <= since + 1'b1;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since == CW'(LAT + 1))); // R2
  AST_RES_HELD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_res)); // R4
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    mis_now |=> mis_sticky); // R7
  AST_CLEAN_NO_MIS: assert property (@(posedge clk) disable iff (rst)
    (flt_sel == 2'd3) |-> !mis_now); // R6
endmodule

bind tmr_mult tmr_mult_chk #(.N(N), .ROWS(ROWS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_res    (out_res),
  .mis_now    (mis_now),
  .mis_sticky (mis_sticky),
  .flt_sel    (flt_sel)
);

// File: tb/tmr_mult_test.sv
module tmr_mult_test;
  localparam int N      = 64;
  localparam int ROWS   = 4;
  localparam int PW     = 2 * N;
  localparam int BW     = $clog2(PW);
  localparam int STAGES = N / ROWS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_a = '0, in_b = '0;
  logic          out_valid;
  logic [N-1:0]  out_res;
  logic          mis_now, mis_sticky;
  logic [1:0]    flt_sel = 2'd3;
  logic [BW-1:0] flt_bit = '0;
  logic          flt_val = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  logic [N-1:0] q_res [$];
  int           q_st  [$];
  logic [N-1:0] prev_res = '0;

  always #10 clk = ~clk;

  tmr_mult #(.N(N), .ROWS(ROWS)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res),
    .mis_now(mis_now), .mis_sticky(mis_sticky),
    .flt_sel(flt_sel), .flt_bit(flt_bit), .flt_val(flt_val)
  );

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R3 unexpected result", out_res, '0);
        end else begin
          logic [N-1:0] er;
          int es;
          er = q_res.pop_front();
          es = q_st.pop_front();
          check(out_res == er, "R1/R5 product", out_res, er);
          if (es != 2)
            check(mis_sticky == es[0], "R7 sticky", N'(mis_sticky), N'(es));
        end
      end else begin
        check(out_res == prev_res, "R4 held result", out_res, prev_res);
      end
      prev_res = out_res;
    end
  end

  // exp_st: 0 clean, 1 disagreement certain, 2 unknown
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        input logic [1:0] fs, input logic [BW-1:0] fb,
                        input logic fv, input int exp_st, input bit poke);
    logic [PW-1:0] p;
    int cnt;
    bit seen;
    p = {{N{1'b0}}, a} * {{N{1'b0}}, b};
    while (!in_ready) @(negedge clk);
    q_res.push_back(p[PW-1:N]);
    q_st.push_back(exp_st);
    flt_sel  = fs;
    flt_bit  = fb;
    flt_val  = fv;
    in_a     = a;
    in_b     = b;
    in_valid = 1'b1;
    @(posedge clk);
    cnt  = 0;
    seen = 1'b0;
    do begin
      @(negedge clk);
      cnt++;
      if (poke && cnt <= 4) begin
        in_valid = 1'b1;
        in_a = ~a;
        in_b = b ^ 64'h5a5a;
        if (cnt == 2)
          check(in_ready == 1'b0, "R3 busy ready", N'(in_ready), '0);
      end else begin
        in_valid = 1'b0;
      end
      if (!out_valid && mis_now) seen = 1'b1;
    end while (!out_valid && cnt < 1000);
    check(cnt - 1 == STAGES + 1, "R2 latency", N'(cnt - 1), N'(STAGES + 1));
    if (exp_st != 2)
      check(seen == exp_st[0], "R6 mis_now", N'(seen), N'(exp_st));
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && out_res == '0 &&
          mis_now == 1'b0 && mis_sticky == 1'b0, "R8 reset",
          {out_res[N-6:0], in_ready, out_valid, mis_now, mis_sticky, 1'b0},
          N'(5'b10000));

    // R1 corner operands, no fault
    run_op('0, '0, 2'd3, '0, 1'b0, 0, 1'b0);
    @(negedge clk);
    run_op('1, '1, 2'd3, '0, 1'b0, 0, 1'b0);
    @(negedge clk);
    run_op(64'h8000_0000_0000_0000, 64'd2, 2'd3, '0, 1'b0, 0, 1'b0);
    @(negedge clk);
    run_op('1, 64'd1, 2'd3, '0, 1'b0, 0, 1'b0);
    // R3 offers while busy are ignored
    @(negedge clk);
    run_op(64'h1234_5678_9abc_def0, 64'hfedc_ba98_7654_3210, 2'd3, '0,
           1'b0, 0, 1'b1);
    // R6 R7: guaranteed disagreement, then back-to-back clean operation
    @(negedge clk);
    run_op('0, 64'hdead_beef, 2'd0, BW'(5), 1'b1, 1, 1'b0);
    run_op(64'hcafe_f00d_0bad_1dea, 64'h0123_4567_89ab_cdef, 2'd3, '0,
           1'b0, 0, 1'b0);
    // R5 faults in each copy with random operands
    for (int i = 0; i < 12; i++) begin
      logic [N-1:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      run_op(ra, rb, 2'(i % 3), BW'($urandom_range(0, PW - 1)),
             1'(i & 1), 2, 1'b0);
    end
    // R1 random clean, back to back
    for (int i = 0; i < 8; i++) begin
      logic [N-1:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      run_op(ra, rb, 2'd3, '0, 1'b0, 0, 1'b0);
    end
    repeat (4) @(negedge clk);
    check(q_res.size() == 0, "R2 all results seen", N'(q_res.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule